// File: doc/BRIEF.md
# Instruction Subset Legality Trap

This block watches the instruction stream of a small 32-bit RISC-V core. It accepts only a narrow subset: the RV32I integer base, the 16-bit compressed integer encodings, and the four multiply instructions. Every word presented with its valid strobe is classified as legal or illegal. The first illegal word latches a trap. The trap drives a halt output that freezes the core, and it stays in force until reset.

The subset leaves out the whole SYSTEM opcode, which covers environment calls, breakpoints, returns from trap, wait-for-interrupt, counter reads and all CSR accesses. It also leaves out the MISC-MEM ordering opcode, divide and remainder, and every floating-point compressed form. The block has no interrupt inputs and no clear path, so only a reset can end the trap.

While trapped, the red LED enable blinks at a 50% duty cycle from a free-running counter. The green and blue enables stay low at all times. The default half-period is 4,500,000 cycles, which gives a period of about 0.5 s at an 18 MHz system clock.

Top module: `insn_guard`

## Requirements
- R1: A word whose low two bits are 11 is decoded as a 32-bit instruction. The following are legal:
  - LUI (0110111), AUIPC (0010111) and JAL (1101111).
  - JALR (1100111) only with funct3 000.
  - BRANCH (1100011) with funct3 other than 010 and 011.
  - LOAD (0000011) with funct3 000, 001, 010, 100 or 101.
  - STORE (0100011) with funct3 000, 001 or 010.
  - OP-IMM (0010011) with any funct3. Shift-left (funct3 001) needs funct7 0000000. Shift-right (funct3 101) needs funct7 0000000 or 0100000.
  - OP (0110011) with funct7 0000000 and any funct3, or with funct7 0100000 and funct3 000 or 101.
- R2: OP with funct7 0000001 is legal for funct3 000 to 011 (the multiply forms). It is illegal for funct3 100 to 111 (divide and remainder).
- R3: Every word with opcode 1110011 (SYSTEM, including CSR and counter access) or 0001111 (fence) is illegal.
- R4: All other 32-bit opcodes, and all funct3/funct7 combinations not listed in R1 or R2, are illegal.
- R5: A word whose low two bits are not 11 is decoded as compressed, using only bits 15:0. The quadrant is bits 1:0 and funct3 is bits 15:13. The following are legal:
  - Quadrant 00: funct3 010 and 110. Funct3 000 is legal with a non-zero bits 12:5.
  - Quadrant 01: funct3 000, 001, 010, 101, 110 and 111.
  - Quadrant 01, funct3 011: legal when {bit12, bits 6:2} is non-zero.
  - Quadrant 01, funct3 100: bits 11:10 = 10 is always legal. The other values of bits 11:10 are legal with bit12 = 0.
  - Quadrant 10: funct3 110. Funct3 000 is legal with bit12 = 0. Funct3 010 is legal with bits 11:7 non-zero. Funct3 100 is legal unless bits 11:7 and bits 6:2 are both zero.
- R6: All other compressed encodings are illegal. This includes the all-zero halfword, compressed EBREAK (0x9002) and every floating-point load or store.
- R7: halt rises on the clock edge that samples insn_valid high with an illegal word. An illegal word presented with insn_valid low has no effect.
- R8: Once high, halt stays high whatever the inputs, until rst_n is asserted. Reset clears halt.
- R9: led_r is low while halt is low. While halt is high, led_r follows a phase that toggles every BLINK_HALF clock cycles.
- R10: led_g and led_b are always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; the only way to leave the trap |
| insn_valid | input | 1 | Qualifies insn_word for checking |
| insn_word | input | 32 | Fetched instruction word |
| halt | output | 1 | Sticky trap; stops the core |
| led_r | output | 1 | Red enable, blinking while trapped |
| led_g | output | 1 | Green enable, held low |
| led_b | output | 1 | Blue enable, held low |

## Verification
A decode fault shows up one cycle after the offending word is sampled: halt is either missing or spurious. Because halt is sticky, a spurious trap also hides every later word until reset. For this reason each vector is checked with a fresh reset behind it.

A faulty trap register shows up as halt dropping under later legal or unqualified input. A faulty blink counter shows up as the spacing between led_r edges differing from BLINK_HALF. It can also show up as red light appearing before any trap.

// File: rtl/insn_guard.sv
module insn_guard #(
  parameter int unsigned BLINK_HALF = 4_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  input  logic [31:0] insn_word,
  output logic        halt,
  output logic        led_r,
  output logic        led_g,
  output logic        led_b
);
  localparam int unsigned CW = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(BLINK_HALF - 1);

  function automatic logic ok32(input logic [31:0] w);
    logic [2:0] f3;
    logic [6:0] f7;
    logic       r;
    f3 = w[14:12];
    f7 = w[31:25];
    case (w[6:0])
      7'b0110111, 7'b0010111, 7'b1101111: r = 1'b1;
      7'b1100111: r = (f3 == 3'd0);
      7'b1100011: r = (f3[2:1] != 2'b01);
      7'b0000011: r = (f3 != 3'd3) && (f3 != 3'd6) && (f3 != 3'd7);
      7'b0100011: r = (f3 <= 3'd2);
      7'b0010011:
        case (f3)
          3'd1:    r = (f7 == 7'h00);
          3'd5:    r = (f7 == 7'h00) || (f7 == 7'h20);
          default: r = 1'b1;
        endcase
      7'b0110011:
        case (f7)
          7'h00:   r = 1'b1;
          7'h20:   r = (f3 == 3'd0) || (f3 == 3'd5);
          7'h01:   r = !f3[2];
          default: r = 1'b0;
        endcase
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic ok16(input logic [15:0] h);
    logic r;
    case ({h[1:0], h[15:13]})
      5'b00_000: r = (h[12:5] != 8'd0);
      5'b00_010, 5'b00_110: r = 1'b1;
      5'b01_000, 5'b01_001, 5'b01_010,
      5'b01_101, 5'b01_110, 5'b01_111: r = 1'b1;
      5'b01_011: r = ({h[12], h[6:2]} != 6'd0);
      5'b01_100: r = (h[11:10] == 2'b10) || !h[12];
      5'b10_000: r = !h[12];
      5'b10_010: r = (h[11:7] != 5'd0);
      5'b10_100: r = (h[11:7] != 5'd0) || (h[6:2] != 5'd0);
      5'b10_110: r = 1'b1;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  logic          legal;
  logic [CW-1:0] cnt;
  logic          phase;

  assign legal = (insn_word[1:0] == 2'b11) ? ok32(insn_word) : ok16(insn_word[15:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   halt <= 1'b0;
    else if (insn_valid && !legal) halt <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + 1'b1;
    end

  assign led_r = halt & phase;
  assign led_g = 1'b0;
  assign led_b = 1'b0;
endmodule

// File: rtl/insn_guard_checker.sv
module insn_guard_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_valid,
  input logic [31:0] insn_word,
  input logic        halt,
  input logic        led_r,
  input logic        led_g,
  input logic        led_b
);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  assert_rise_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !insn_valid) |=> !halt);

  assert_system_traps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_word[6:0] == 7'b1110011) |=> halt);

  assert_divide_traps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_word[6:0] == 7'b0110011 && insn_word[31:25] == 7'h01
     && insn_word[14]) |=> halt);

  assert_zero_half_traps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_word[15:0] == 16'h0000) |=> halt);

  assert_dark_when_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |-> !led_r);

  assert_green_blue_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !led_g && !led_b);
endmodule

bind insn_guard insn_guard_checker u_insn_guard_checker (
  .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
  .halt(halt), .led_r(led_r), .led_g(led_g), .led_b(led_b)
);

// File: tb/test_insn_guard.sv
module test_insn_guard;
  localparam int unsigned HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn_word = 32'h0;
  logic        halt, led_r, led_g, led_b;

  int vectors = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  insn_guard #(.BLINK_HALF(HALF)) i_insn_guard (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .halt(halt), .led_r(led_r), .led_g(led_g), .led_b(led_b)
  );

  function automatic bit ref_legal(input logic [31:0] w);
    logic [15:0] h = w[15:0];
    logic [2:0]  f3 = w[14:12];
    logic [6:0]  f7 = w[31:25];
    if (w[1:0] == 2'b11) begin
      if (w[6:0] inside {7'h37, 7'h17, 7'h6f}) return 1;
      if (w[6:0] == 7'h67) return f3 == 0;
      if (w[6:0] == 7'h63) return !(f3 inside {3'd2, 3'd3});
      if (w[6:0] == 7'h03) return f3 inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd5};
      if (w[6:0] == 7'h23) return f3 inside {3'd0, 3'd1, 3'd2};
      if (w[6:0] == 7'h13) begin
        if (f3 == 1) return f7 == 0;
        if (f3 == 5) return f7 inside {7'h00, 7'h20};
        return 1;
      end
      if (w[6:0] == 7'h33) begin
        if (f7 == 0) return 1;
        if (f7 == 7'h20) return f3 inside {3'd0, 3'd5};
        if (f7 == 7'h01) return f3 < 4;
        return 0;
      end
      return 0;
    end
    if (h[1:0] == 0) begin
      if (h[15:13] == 0) return h[12:5] != 0;
      return h[15:13] inside {3'd2, 3'd6};
    end
    if (h[1:0] == 1) begin
      if (h[15:13] == 3) return {h[12], h[6:2]} != 0;
      if (h[15:13] == 4) return h[12] == 0 || h[11:10] == 2'b10;
      return 1;
    end
    case (h[15:13])
      3'd0: return !h[12];
      3'd2: return h[11:7] != 0;
      3'd4: return !(h[11:7] == 0 && h[6:2] == 0);
      3'd6: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    if (w[1:0] != 2'b11) return ref_legal(w) ? "R5" : "R6";
    if (w[6:0] == 7'h73 || w[6:0] == 7'h0f) return "R3";
    if (w[6:0] == 7'h33 && w[31:25] == 7'h01) return "R2";
    return ref_legal(w) ? "R1" : "R4";
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; insn_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk); insn_word = w; insn_valid = 1'b1;
    @(negedge clk); insn_valid = 1'b0;
    check(halt, !ref_legal(w), tag_of(w), $sformatf("word %08h", w));
    if (halt) do_reset();
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    int last_t, edges;
    logic prev;
    void'($urandom(32'd20240611));
    do_reset();
    check(halt, 1'b0, "R8", "reset halt");
    check(led_r, 1'b0, "R9", "reset led_r");

    // directed 32-bit
    apply(32'h000002b7); apply(32'h00000013); apply(32'h40000033); apply(32'h40005033);
    apply(32'h40005013); apply(32'h40001013); apply(32'h40001033); apply(32'h00001067);
    apply(32'h00003003); apply(32'h02208033); apply(32'h0220b033); apply(32'h0220c033);
    apply(32'h0220f033); apply(32'h00000073); apply(32'h00100073); apply(32'h30200073);
    apply(32'h10500073); apply(32'h00001073); apply(32'hc0002073); apply(32'h0ff0000f);
    apply(32'h0000100f); apply(32'h0000005b);
    // directed compressed
    apply(32'h00000000); apply(32'h00009002); apply(32'h00000001); apply(32'h00004501);
    apply(32'h00008082); apply(32'h00008002); apply(32'h00002000); apply(32'h00006000);
    apply(32'h00000004); apply(32'h00000040); apply(32'hffff0001); apply(32'h00009c01);

    // random sweep
    for (int i = 0; i < 3000; i++) begin
      w = $urandom;
      case ($urandom_range(3))
        0: w[1:0] = 2'b11;
        1: begin w[1:0] = 2'b11; w[6:2] = 5'b01100;
             w[31:25] = (($urandom_range(3)) == 0) ? 7'h20 : 7'h01; end
        2: begin w[1:0] = 2'b11; w[6:0] = 7'h13; end
        default: w[1:0] = 2'($urandom_range(2));
      endcase
      apply(w);
    end

    // R7: unqualified illegal word is ignored
    @(negedge clk); insn_word = 32'h00000073; insn_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    check(halt, 1'b0, "R7", "illegal word without valid");

    // R9: dark while running
    prev = 1'b0;
    for (int i = 0; i < 4 * HALF; i++) begin
      @(negedge clk); insn_word = 32'h00000013; insn_valid = 1'b1;
      if (led_r) prev = 1'b1;
    end
    insn_valid = 1'b0;
    check(prev, 1'b0, "R9", "led_r while not halted");

    // R7: halt rises exactly one edge after the offending word
    @(negedge clk); insn_word = 32'h0220d033; insn_valid = 1'b1;
    check(halt, 1'b0, "R7", "halt before sampling edge");
    @(negedge clk); insn_valid = 1'b0;
    check(halt, 1'b1, "R7", "halt after sampling edge");

    // R8 sticky, R9 blink spacing, R10 green/blue
    last_t = -1; edges = 0; prev = led_r;
    for (int t = 0; t < 12 * HALF; t++) begin
      @(negedge clk);
      insn_valid = 1'($urandom_range(1));
      insn_word = 32'h00000013;
      if (!halt) begin errors++; $display("FAIL R8 halt dropped: actual 0 expected 1"); end
      if (led_g || led_b) begin errors++; $display("FAIL R10 green/blue: actual %b%b expected 00", led_g, led_b); end
      if (led_r !== prev) begin
        if (last_t >= 0) check(1'((t - last_t) == HALF), 1'b1, "R9",
                               $sformatf("blink spacing %0d vs %0d", t - last_t, HALF));
        last_t = t; edges++;
        prev = led_r;
      end
    end
    vectors++;
    insn_valid = 1'b0;
    check(1'(edges >= 10), 1'b1, "R9", "blink edge count");
    check(halt, 1'b1, "R8", "halt after noise");

    do_reset();
    check(halt, 1'b0, "R8", "reset clears halt");
    check(led_r, 1'b0, "R9", "led_r after reset");
    check(led_g | led_b, 1'b0, "R10", "green/blue after reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule